// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small accumulator machine. Each cycle it takes the accumulator value, a second operand and a four-bit operation code, and it computes the result combinationally. The carry input, and the half-carry input used by decimal adjust, come from the block's own stored status byte. Alongside the result it produces the status byte that the operation would leave behind and a flag that tells the surrounding datapath whether the accumulator should take the result. The status byte is registered and is loaded only on a clock edge where the flag-write enable is high.

It supports binary add and subtract, each with or without the stored carry, and the three bitwise operations. It also has compare, increment by one, decrement by one, four single-bit accumulator rotates, and a packed-BCD decimal correction. Every operation class touches only its own set of flags, so a rotate keeps the zero and sign state from an earlier add, and an increment keeps the carry.

Top module: `acc_alu8`

## Requirements
- R1: Operation codes are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, CMP=7, INC=8, DEC=9, RLC=10, RRC=11, RAL=12, RAR=13, DAA=14, HOLD=15. ADD gives acc+opnd and ADC gives acc+opnd+CY, both modulo 256. CY is the carry out of bit 7.
- R2: SUB gives acc-opnd and SBB gives acc-opnd-CY, both modulo 256. CY is set exactly when the true difference is negative (a borrow).
- R3: For ADD and ADC, AC is the carry out of bit 3. For SUB, SBB and CMP, AC is set when the low nibble needs no borrow: acc[3:0] >= opnd[3:0] + borrow-in.
- R4: For every operation except rotates and HOLD, S = result bit 7, Z = (result == 0) and P = (result has an even count of ones). For CMP these are taken from the difference.
- R5: INC and DEC return acc+1 and acc-1. INC sets AC when acc[3:0] is 0xF. DEC sets AC when acc[3:0] is not 0. CY keeps its stored value.
- R6: AND returns acc & opnd, sets AC to 1 and clears CY.
- R7: OR and XOR return acc | opnd and acc ^ opnd, and clear both AC and CY.
- R8: CMP leaves the accumulator alone: acc_we_o is 0 and res_o equals acc_i. Its flags are those SUB would produce.
- R9: RLC moves bit 7 into bit 0 and into CY. RRC moves bit 0 into bit 7 and into CY, so 0x03 becomes 0x81 with CY=1. RAL shifts left with the old CY entering bit 0 and bit 7 leaving into CY. RAR is the mirror of RAL. All other flags stay as stored.
- R10: DAA adds 0x06 when acc[3:0] > 9 or AC is set. It then adds 0x60 when CY is set, when that first step carries past bit 7, or when the high nibble after the first step exceeds 9. CY equals whether 0x60 was added. AC is the carry out of bit 3 of the total addition. Example: 0x4B becomes 0x51.
- R11: The status byte is S at bit 7, Z at 6, AC at 4, P at 2 and CY at 0. Bits 5, 3 and 1 are always 0.
- R12: The stored status byte resets to 0x00 on a synchronous reset. It loads flags_nxt_o on a rising edge only while flag_we_i is high.
- R13: HOLD returns acc_i with acc_we_o = 0, and its next status byte equals the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| op_i | input | 4 | Operation code |
| flag_we_i | input | 1 | Load the status register on this edge |
| res_o | output | 8 | Operation result |
| acc_we_o | output | 1 | Result should be written to the accumulator |
| flags_nxt_o | output | 8 | Status byte this operation produces |
| flags_q_o | output | 8 | Stored status byte |

## Verification
The bench builds the block with its default eight-bit data width, which is the only width the nibble-based half-carry and decimal correction are defined for. At that width every operand pair, op code and stored-flag state is reachable. The random stream, with the flag-write enable randomly on or off, therefore lands on carry-dependent paths: ADC, SBB, the rotates through carry, and DAA with AC or CY already set. Directed cases pin the wraparound, borrow, equal-compare and decimal examples.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int FLAG_W = 8;
  localparam int F_S    = 7;
  localparam int F_Z    = 6;
  localparam int F_AC   = 4;
  localparam int F_P    = 2;
  localparam int F_CY   = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_AND  = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_CMP = 4'd7,
    OP_INC  = 4'd8,  OP_DEC = 4'd9,  OP_RLC = 4'd10, OP_RRC = 4'd11,
    OP_RAL  = 4'd12, OP_RAR = 4'd13, OP_DAA = 4'd14, OP_HOLD = 4'd15
  } alu_op_e;

  function automatic logic [FLAG_W-1:0] pack_flags(input logic s, input logic z,
                                                   input logic ac, input logic p,
                                                   input logic cy);
    logic [FLAG_W-1:0] f;
    f = '0;
    f[F_S]  = s;
    f[F_Z]  = z;
    f[F_AC] = ac;
    f[F_P]  = p;
    f[F_CY] = cy;
    return f;
  endfunction
endpackage

// File: rtl/acc_alu8_addsub.sv
module acc_alu8_addsub
  import acc_alu8_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int NIB = NIB_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         cy_in,
  output logic [W-1:0] sum,
  output logic         cy_out,
  output logic         hc_out
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] bb;
  logic         ci;
  logic         sub_like;
  logic [W:0]   full;

  always_comb begin
    bb       = b;
    ci       = 1'b0;
    sub_like = 1'b0;
    unique case (op)
      OP_ADD: begin bb = b;    ci = 1'b0;   end
      OP_ADC: begin bb = b;    ci = cy_in;  end
      OP_SUB, OP_CMP: begin bb = ~b; ci = 1'b1; sub_like = 1'b1; end
      OP_SBB: begin bb = ~b;   ci = ~cy_in; sub_like = 1'b1; end
      OP_INC: begin bb = ONE;  ci = 1'b0;   end
      OP_DEC: begin bb = ~ONE; ci = 1'b1;   end
      default: begin bb = b;   ci = 1'b0;   end
    endcase
  end

  assign full   = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, ci};
  assign sum    = full[W-1:0];
  assign hc_out = a[NIB] ^ bb[NIB] ^ full[NIB];
  assign cy_out = sub_like ? ~full[W] : full[W];
endmodule

// File: rtl/acc_alu8_logrot.sv
module acc_alu8_logrot
  import acc_alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         ac_out
);
  always_comb begin
    res    = a;
    cy_out = cy_in;
    ac_out = 1'b0;
    unique case (op)
      OP_AND: begin res = a & b; cy_out = 1'b0; ac_out = 1'b1; end
      OP_OR:  begin res = a | b; cy_out = 1'b0; end
      OP_XOR: begin res = a ^ b; cy_out = 1'b0; end
      OP_RLC: begin res = {a[W-2:0], a[W-1]}; cy_out = a[W-1]; end
      OP_RRC: begin res = {a[0], a[W-1:1]};   cy_out = a[0];   end
      OP_RAL: begin res = {a[W-2:0], cy_in};  cy_out = a[W-1]; end
      OP_RAR: begin res = {cy_in, a[W-1:1]};  cy_out = a[0];   end
      default: begin res = a; cy_out = cy_in; ac_out = 1'b0; end
    endcase
  end
endmodule

// File: rtl/acc_alu8_daa.sv
module acc_alu8_daa
  import acc_alu8_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int NIB = NIB_W
) (
  input  logic [W-1:0] a,
  input  logic         ac_in,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         ac_out
);
  localparam logic [NIB-1:0] NINE = NIB'(9);
  localparam logic [NIB-1:0] SIX  = NIB'(6);

  logic           lo_fix;
  logic           hi_fix;
  logic [W:0]     step1;
  logic [W-1:0]   corr;
  logic [W-1:0]   total;

  assign lo_fix = (a[NIB-1:0] > NINE) | ac_in;
  assign step1  = {1'b0, a} + {{(W-NIB+1){1'b0}}, (lo_fix ? SIX : {NIB{1'b0}})};
  assign hi_fix = cy_in | step1[W] | (step1[W-1:NIB] > NINE);
  assign corr   = {(hi_fix ? SIX : {NIB{1'b0}}), (lo_fix ? SIX : {NIB{1'b0}})};
  assign total  = a + corr;

  assign res    = total;
  assign cy_out = hi_fix;
  assign ac_out = a[NIB] ^ corr[NIB] ^ total[NIB];
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu8_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int NIB = NIB_W,
  parameter int FW  = FLAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  acc_i,
  input  logic [W-1:0]  opnd_i,
  input  logic [3:0]    op_i,
  input  logic          flag_we_i,
  output logic [W-1:0]  res_o,
  output logic          acc_we_o,
  output logic [FW-1:0] flags_nxt_o,
  output logic [FW-1:0] flags_q_o
);
  localparam logic [FW-1:0] UNUSED_MASK = ~pack_flags(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);

  alu_op_e       op;
  logic [FW-1:0] flags_q;
  logic [FW-1:0] flags_nxt;
  logic          cy_q;
  logic          ac_q;

  logic [W-1:0]  as_sum;
  logic          as_cy, as_hc;
  logic [W-1:0]  lr_res;
  logic          lr_cy, lr_ac;
  logic [W-1:0]  da_res;
  logic          da_cy, da_ac;

  assign op   = alu_op_e'(op_i);
  assign cy_q = flags_q[F_CY];
  assign ac_q = flags_q[F_AC];

  acc_alu8_addsub #(.W(W), .NIB(NIB)) u_addsub (
    .a(acc_i), .b(opnd_i), .op(op), .cy_in(cy_q),
    .sum(as_sum), .cy_out(as_cy), .hc_out(as_hc)
  );

  acc_alu8_logrot #(.W(W)) u_logrot (
    .a(acc_i), .b(opnd_i), .op(op), .cy_in(cy_q),
    .res(lr_res), .cy_out(lr_cy), .ac_out(lr_ac)
  );

  acc_alu8_daa #(.W(W), .NIB(NIB)) u_daa (
    .a(acc_i), .ac_in(ac_q), .cy_in(cy_q),
    .res(da_res), .cy_out(da_cy), .ac_out(da_ac)
  );

  function automatic logic [FW-1:0] szp_flags(input logic [W-1:0] r,
                                              input logic ac, input logic cy);
    return pack_flags(r[W-1], ~|r, ac, ~^r, cy);
  endfunction

  always_comb begin
    res_o     = acc_i;
    acc_we_o  = 1'b0;
    flags_nxt = flags_q;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_o     = as_sum;
        acc_we_o  = 1'b1;
        flags_nxt = szp_flags(as_sum, as_hc, as_cy);
      end
      OP_CMP: begin
        res_o     = acc_i;
        acc_we_o  = 1'b0;
        flags_nxt = szp_flags(as_sum, as_hc, as_cy);
      end
      OP_INC, OP_DEC: begin
        res_o     = as_sum;
        acc_we_o  = 1'b1;
        flags_nxt = szp_flags(as_sum, as_hc, cy_q);
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o     = lr_res;
        acc_we_o  = 1'b1;
        flags_nxt = szp_flags(lr_res, lr_ac, lr_cy);
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res_o           = lr_res;
        acc_we_o        = 1'b1;
        flags_nxt       = flags_q;
        flags_nxt[F_CY] = lr_cy;
      end
      OP_DAA: begin
        res_o     = da_res;
        acc_we_o  = 1'b1;
        flags_nxt = szp_flags(da_res, da_ac, da_cy);
      end
      default: begin
        res_o     = acc_i;
        acc_we_o  = 1'b0;
        flags_nxt = flags_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            flags_q <= '0;
    else if (flag_we_i) flags_q <= flags_nxt & ~UNUSED_MASK;
  end

  assign flags_nxt_o = flags_nxt;
  assign flags_q_o   = flags_q;

  // R12: register holds without write enable
  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !flag_we_i |=> $stable(flags_q));
  // R12: register takes the next byte when enabled
  a_r12_load_when_enabled: assert property (@(posedge clk) disable iff (rst)
    flag_we_i |=> flags_q == $past(flags_nxt));
  // R11: unused positions stay clear in both bytes
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (rst)
    ((flags_nxt | flags_q) & UNUSED_MASK) == '0);
  // R5: increment and decrement keep the stored carry
  a_r5_cy_kept: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC || op == OP_DEC) |-> flags_nxt[F_CY] == flags_q[F_CY]);
  // R8: compare never writes the accumulator
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |-> (!acc_we_o && res_o == acc_i));
  // R9: rotates touch only the carry
  a_r9_rot_carry_only: assert property (@(posedge clk) disable iff (rst)
    (op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR}) |->
      (flags_nxt[FW-1:1] == flags_q[FW-1:1]));
  // R10: a stored carry survives decimal adjust
  a_r10_cy_sticky: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DAA && flags_q[F_CY]) |-> flags_nxt[F_CY]);
  // R13: hold leaves everything unchanged
  a_r13_hold_same: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |-> (flags_nxt == flags_q && !acc_we_o && res_o == acc_i));
endmodule

// File: tb/tb_acc_alu8.sv
module tb_acc_alu8;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic [3:0] op_i = 4'd15;
  logic       flag_we_i = 1'b0;
  logic [7:0] res_o, flags_nxt_o, flags_q_o;
  logic       acc_we_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] mflags = 8'h00;

  acc_alu8 dut (
    .clk(clk), .rst(rst), .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i),
    .flag_we_i(flag_we_i), .res_o(res_o), .acc_we_o(acc_we_o),
    .flags_nxt_o(flags_nxt_o), .flags_q_o(flags_q_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mk(input logic s, z, ac, p, cy);
    return {s, z, 1'b0, ac, 1'b0, p, 1'b0, cy};
  endfunction

  // returns {res, acc_we, flags}
  function automatic logic [16:0] ref_model(input logic [3:0] op, input logic [7:0] a8,
                                            input logic [7:0] b8, input logic [7:0] f);
    int a, b, r, cy, ac, lo, cor, t;
    logic [7:0] res, d, fl;
    logic awe, nc, nac;
    a = a8; b = b8; cy = f[0]; ac = f[4]; lo = a % 16;
    awe = 1'b1; nc = f[0]; nac = 1'b0; res = a8; fl = f; d = a8;
    case (op)
      4'd0, 4'd1: begin
        r = a + b + ((op == 4'd1) ? cy : 0);
        d = r[7:0]; nc = (r > 255);
        nac = ((lo + b % 16 + ((op == 4'd1) ? cy : 0)) > 15);
      end
      4'd2, 4'd3, 4'd7: begin
        r = a - b - ((op == 4'd3) ? cy : 0);
        d = r[7:0]; nc = (r < 0);
        nac = (lo >= (b % 16) + ((op == 4'd3) ? cy : 0));
      end
      4'd8: begin d = 8'(a + 1); nac = (lo == 15); nc = f[0]; end
      4'd9: begin d = 8'(a - 1); nac = (lo != 0);  nc = f[0]; end
      4'd4: begin d = a8 & b8; nac = 1'b1; nc = 1'b0; end
      4'd5: begin d = a8 | b8; nac = 1'b0; nc = 1'b0; end
      4'd6: begin d = a8 ^ b8; nac = 1'b0; nc = 1'b0; end
      4'd14: begin
        cor = 0; nc = 1'b0;
        if (lo > 9 || ac != 0) cor = 6;
        t = a + cor;
        if (cy != 0 || t > 255 || ((t >> 4) % 16) > 9) begin cor = cor + 96; nc = 1'b1; end
        r = a + cor; d = r[7:0];
        nac = (((a % 16) + (cor % 16)) > 15);
      end
      default: ;
    endcase
    case (op)
      4'd10: begin res = {a8[6:0], a8[7]}; fl = f; fl[0] = a8[7]; end
      4'd11: begin res = {a8[0], a8[7:1]}; fl = f; fl[0] = a8[0]; end
      4'd12: begin res = {a8[6:0], f[0]}; fl = f; fl[0] = a8[7]; end
      4'd13: begin res = {f[0], a8[7:1]}; fl = f; fl[0] = a8[0]; end
      4'd15: begin res = a8; awe = 1'b0; fl = f; end
      4'd7:  begin res = a8; awe = 1'b0; fl = mk(d[7], d == 0, nac, ~^d, nc); end
      default: begin res = d; fl = mk(d[7], d == 0, nac, ~^d, nc); end
    endcase
    return {res, awe, fl};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3: return "R2";
      4'd4: return "R6";
      4'd5, 4'd6: return "R7";
      4'd7: return "R8";
      4'd8, 4'd9: return "R5";
      4'd14: return "R10";
      4'd15: return "R13";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // drives one operation, checks outputs before the edge and the register after it
  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic we);
    logic [16:0] e;
    @(negedge clk);
    acc_i = a; opnd_i = b; op_i = op; flag_we_i = we;
    #2;
    e = ref_model(op, a, b, mflags);
    check(tag_of(op), "result", res_o, e[16:9]);
    check(tag_of(op), "acc_we", {7'd0, acc_we_o}, {7'd0, e[8]});
    check(tag_of(op), "flags_nxt (R3 R4 R11)", flags_nxt_o, e[7:0]);
    @(posedge clk);
    if (we) mflags = e[7:0];
    #2;
    check("R12", "flags_q", flags_q_o, mflags);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2 check("R12", "reset flags", flags_q_o, 8'h00);

    run_op(4'd0, 8'h12, 8'h39, 1'b1);   // R1: 0x4B
    run_op(4'd14, 8'h4B, 8'h00, 1'b1);  // R10: 0x51
    run_op(4'd11, 8'h03, 8'h00, 1'b1);  // R9: 0x81, CY set
    run_op(4'd0, 8'hFF, 8'h01, 1'b1);   // R1 R3: zero, carry, half carry
    run_op(4'd1, 8'h10, 8'h20, 1'b1);   // R1: ADC uses carry
    run_op(4'd2, 8'h10, 8'h20, 1'b1);   // R2: borrow
    run_op(4'd3, 8'h20, 8'h0F, 1'b1);   // R2: SBB with borrow in
    run_op(4'd7, 8'h55, 8'h55, 1'b1);   // R8: equal compare
    run_op(4'd0, 8'h80, 8'h80, 1'b1);   // set CY
    run_op(4'd8, 8'hFF, 8'h00, 1'b1);   // R5: CY kept
    run_op(4'd9, 8'h10, 8'h00, 1'b1);   // R5: low nibble borrow
    run_op(4'd4, 8'hF3, 8'h3C, 1'b1);   // R6
    run_op(4'd5, 8'h30, 8'h10, 1'b1);   // R7
    run_op(4'd6, 8'h17, 8'h17, 1'b1);   // R7: zero result
    run_op(4'd0, 8'h09, 8'h09, 1'b1);   // AC set
    run_op(4'd14, 8'h12, 8'h00, 1'b1);  // R10: AC-driven correction -> 0x18
    run_op(4'd0, 8'h99, 8'h01, 1'b1);
    run_op(4'd14, 8'h9A, 8'h00, 1'b1);  // R10: 0x00 with CY
    run_op(4'd12, 8'h40, 8'h00, 1'b1);  // R9: RAL with CY in
    run_op(4'd13, 8'h01, 8'h00, 1'b1);  // R9: RAR
    run_op(4'd10, 8'h81, 8'h00, 1'b1);  // R9: RLC
    run_op(4'd15, 8'hA5, 8'h5A, 1'b1);  // R13
    run_op(4'd2, 8'h00, 8'h01, 1'b0);   // R12: write disabled

    for (int i = 0; i < 3000; i++)
      run_op(4'($urandom % 16), 8'($urandom), 8'($urandom), 1'($urandom % 2));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule